// File: doc/BRIEF.md
# Conversion Result Holding Register with Read Lock

This block keeps the most recent result produced by an analog-to-digital conversion sequencer and presents it on a byte-wide read bus. The result is split into a low byte and a high byte. A mode bit picks how the result is aligned within the 16-bit pair. By default the result sits against the least significant end. With the mode bit set it sits against the most significant end, so a reader that needs only 8 bits of precision can fetch the high byte alone.

A reader that wants the full result fetches the low byte first and then the high byte. Fetching the low byte freezes the pair. Fetching the high byte releases it. Any result that arrives while the pair is frozen is discarded, so both bytes of a read always belong to the same conversion. Every write strobe from the sequencer is still passed on as a completion pulse to the interrupt flag logic, whether or not the result was stored.

Top module: `adc_result_regs`

## Requirements
- R1: With `left_adj` low, the low byte reads result[7:0]. The high byte reads result[9:8] in bits 1:0, and bits 7:2 read zero.
- R2: With `left_adj` high, the high byte reads result[9:2]. The low byte reads result[1:0] in bits 7:6, and bits 5:0 read zero.
- R3: A change of `left_adj` takes effect on the very next read, with no new write needed.
- R4: A cycle with `rd_lo` high locks the pair from the following cycle on. While the pair is locked, a `res_wr` strobe changes neither byte.
- R5: A cycle with `rd_hi` high unlocks the pair from the following cycle on. The next write is then stored.
- R6: A `res_wr` strobe in the same cycle as `rd_lo` is discarded. The bytes read afterwards stay those of the earlier result.
- R7: `cc_pulse` is high for exactly the one cycle after each `res_wr` strobe, whether the result was stored or discarded.
- R8: Reset clears the stored result to zero, unlocks the pair and drops `cc_pulse`.
- R9: `rd_data` shows the low byte when `rd_lo` is high, the high byte when only `rd_hi` is high, and zero when neither is high. A read of both bytes in one cycle leaves the pair unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_wr | input | 1 | Result write strobe from the conversion sequencer |
| res_data | input | 10 | Conversion result |
| left_adj | input | 1 | 1 = left-justified, 0 = right-justified |
| rd_lo | input | 1 | Low byte read strobe |
| rd_hi | input | 1 | High byte read strobe |
| rd_data | output | 8 | Read data, combinational from the strobes |
| cc_pulse | output | 1 | Conversion-complete pulse to the interrupt flag logic |

## Verification
The assertions assume that each read strobe is a single-cycle pulse issued by a bus that holds `left_adj` steady during the read. They also assume that `res_data` is meaningful only in a cycle where `res_wr` is high. The stimulus changes every input on the falling clock edge and raises each strobe for exactly one cycle. It samples `rd_data` in the same cycle, before the edge at which the strobe's effect on the lock is applied. The coincident write-and-read case is driven on purpose, to exercise the drop rule.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
   localparam int DEF_RES_W = 10;
   localparam int DEF_BUS_W = 8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_LO   = 2'b01,
      SEL_HI   = 2'b10
   } byte_sel_e;

   function automatic byte_sel_e pick_sel(input logic lo, input logic hi);
      if (lo)      return SEL_LO;
      else if (hi) return SEL_HI;
      else         return SEL_NONE;
   endfunction
endpackage

// File: rtl/adc_res_store.sv
module adc_res_store #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_wr,
   input  logic [RES_W-1:0] res_data,
   input  logic             rd_lo,
   input  logic             rd_hi,
   output logic [RES_W-1:0] raw_q,
   output logic             lock_q,
   output logic             cc_pulse
);
   logic accept;
   logic lock_d;

   assign accept = res_wr & ~lock_q & ~rd_lo;

   always_comb begin
      lock_d = lock_q;
      if (rd_hi)      lock_d = 1'b0;
      else if (rd_lo) lock_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q    <= '0;
         lock_q   <= 1'b0;
         cc_pulse <= 1'b0;
      end else begin
         lock_q   <= lock_d;
         cc_pulse <= res_wr;
         if (accept) raw_q <= res_data;
      end
   end

   assert_locked_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(raw_q));

   assert_coincident_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && res_wr) |=> $stable(raw_q));

   assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> !lock_q);

   assert_lock_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !rd_hi) |=> lock_q);

   assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_wr && !lock_q && !rd_lo) |=> (raw_q == $past(res_data)));

   assert_cc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |=> cc_pulse);

   assert_cc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !res_wr |=> !cc_pulse);
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align #(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic [RES_W-1:0]   raw,
   input  logic               left_adj,
   output logic [2*BUS_W-1:0] word
);
   localparam int PAIR_W = 2 * BUS_W;
   localparam int PAD_W  = PAIR_W - RES_W;

   generate
      if (PAD_W == 0) begin : g_full
         assign word = raw;
      end else begin : g_pad
         logic [PAIR_W-1:0] right_w;
         logic [PAIR_W-1:0] left_w;
         assign right_w = {{PAD_W{1'b0}}, raw};
         assign left_w  = {raw, {PAD_W{1'b0}}};
         assign word    = left_adj ? left_w : right_w;
      end
   endgenerate
endmodule

// File: rtl/adc_res_rdmux.sv
module adc_res_rdmux
   import adc_res_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic [2*BUS_W-1:0] word,
   input  logic               rd_lo,
   input  logic               rd_hi,
   output logic [BUS_W-1:0]   rd_data
);
   byte_sel_e sel;

   assign sel = pick_sel(rd_lo, rd_hi);

   always_comb begin
      unique case (sel)
         SEL_LO:  rd_data = word[BUS_W-1:0];
         SEL_HI:  rd_data = word[2*BUS_W-1:BUS_W];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
   import adc_res_pkg::*;
#(
   parameter int RES_W = DEF_RES_W,
   parameter int BUS_W = DEF_BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_wr,
   input  logic [RES_W-1:0] res_data,
   input  logic             left_adj,
   input  logic             rd_lo,
   input  logic             rd_hi,
   output logic [BUS_W-1:0] rd_data,
   output logic             cc_pulse
);
   localparam int PAIR_W = 2 * BUS_W;
   localparam int PAD_W  = PAIR_W - RES_W;

   generate
      if (RES_W <= BUS_W || RES_W > PAIR_W) begin : g_bad_width
         $error("adc_result_regs: RES_W must lie in (BUS_W, 2*BUS_W]");
      end
   endgenerate

   logic [RES_W-1:0]  raw_q;
   logic              lock_q;
   logic [PAIR_W-1:0] word;

   adc_res_store #(.RES_W(RES_W)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .res_wr   (res_wr),
      .res_data (res_data),
      .rd_lo    (rd_lo),
      .rd_hi    (rd_hi),
      .raw_q    (raw_q),
      .lock_q   (lock_q),
      .cc_pulse (cc_pulse)
   );

   adc_res_align #(.RES_W(RES_W), .BUS_W(BUS_W)) align_i (
      .raw      (raw_q),
      .left_adj (left_adj),
      .word     (word)
   );

   adc_res_rdmux #(.BUS_W(BUS_W)) rdmux_i (
      .word    (word),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi),
      .rd_data (rd_data)
   );

   generate
      if (PAD_W > 0) begin : g_pad_chk
         assert_right_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hi && !rd_lo && !left_adj) |-> (rd_data[BUS_W-1:RES_W-BUS_W] == '0));
         assert_left_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lo && left_adj) |-> (rd_data[PAD_W-1:0] == '0));
      end
   endgenerate

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_lo && !rd_hi) |-> (rd_data == '0));
endmodule

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       res_wr = 1'b0;
   logic [9:0] res_data = '0;
   logic       left_adj = 1'b0;
   logic       rd_lo = 1'b0;
   logic       rd_hi = 1'b0;
   logic [7:0] rd_data;
   logic       cc_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   adc_result_regs dut_i (
      .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_data(res_data),
      .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .rd_data(rd_data), .cc_pulse(cc_pulse)
   );

   typedef struct packed {
      logic       adj;
      logic [9:0] res;
      logic [7:0] lo;
      logic [7:0] hi;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{1'b0, 10'h3FF, 8'hFF, 8'h03},
      '{1'b1, 10'h3FF, 8'hC0, 8'hFF},
      '{1'b0, 10'h2A5, 8'hA5, 8'h02},
      '{1'b1, 10'h2A5, 8'h40, 8'hA9},
      '{1'b0, 10'h155, 8'h55, 8'h01},
      '{1'b1, 10'h155, 8'h40, 8'h55},
      '{1'b0, 10'h000, 8'h00, 8'h00},
      '{1'b1, 10'h000, 8'h00, 8'h00},
      '{1'b0, 10'h201, 8'h01, 8'h02},
      '{1'b1, 10'h201, 8'h40, 8'h80}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic write_res(input logic [9:0] v);
      @(negedge clk);
      res_wr = 1'b1; res_data = v;
      @(negedge clk);
      res_wr = 1'b0;
      check("R7 pulse after write", {7'd0, cc_pulse}, 8'h01);
   endtask

   task automatic read_byte(input logic lo, input logic hi, output logic [7:0] v);
      @(negedge clk);
      rd_lo = lo; rd_hi = hi;
      #1 v = rd_data;
      @(negedge clk);
      rd_lo = 1'b0; rd_hi = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 cc_pulse low after reset", {7'd0, cc_pulse}, 8'h00);
      rst_n = 1'b1;
      read_byte(1'b0, 1'b1, b); check("R8 high byte zero", b, 8'h00);
      read_byte(1'b1, 1'b0, b); check("R8 low byte zero", b, 8'h00);
      read_byte(1'b0, 1'b1, b);

      // R1 / R2: table walk, low byte then high byte
      foreach (VECS[i]) begin
         left_adj = VECS[i].adj;
         write_res(VECS[i].res);
         read_byte(1'b1, 1'b0, b);
         check(VECS[i].adj ? "R2 low byte" : "R1 low byte", b, VECS[i].lo);
         read_byte(1'b0, 1'b1, b);
         check(VECS[i].adj ? "R2 high byte" : "R1 high byte", b, VECS[i].hi);
      end

      // R3: realign without a new write (stored 0x201)
      left_adj = 1'b0;
      read_byte(1'b0, 1'b1, b); check("R3 high right", b, 8'h02);
      left_adj = 1'b1;
      read_byte(1'b0, 1'b1, b); check("R3 high left", b, 8'h80);

      // R4 / R5: locked write dropped, unlock lets next write through
      left_adj = 1'b0;
      write_res(10'h1C3);
      read_byte(1'b1, 1'b0, b); check("R4 low before lock", b, 8'hC3);
      write_res(10'h27E);
      read_byte(1'b0, 1'b1, b); check("R4 high kept while locked", b, 8'h01);
      read_byte(1'b1, 1'b0, b); check("R4 low kept while locked", b, 8'hC3);
      read_byte(1'b0, 1'b1, b);
      write_res(10'h27E);
      read_byte(1'b1, 1'b0, b); check("R5 low after unlock", b, 8'h7E);
      read_byte(1'b0, 1'b1, b); check("R5 high after unlock", b, 8'h02);

      // R6: write in the same cycle as the low read is dropped
      @(negedge clk);
      res_wr = 1'b1; res_data = 10'h3A1; rd_lo = 1'b1;
      #1 b = rd_data; check("R6 low shows earlier result", b, 8'h7E);
      @(negedge clk);
      res_wr = 1'b0; rd_lo = 1'b0;
      check("R7 pulse on dropped write", {7'd0, cc_pulse}, 8'h01);
      read_byte(1'b0, 1'b1, b); check("R6 high shows earlier result", b, 8'h02);
      @(negedge clk);
      check("R7 pulse lasts one cycle", {7'd0, cc_pulse}, 8'h00);

      // R9: idle bus and combined read
      #1 check("R9 idle zero", rd_data, 8'h00);
      read_byte(1'b1, 1'b1, b); check("R9 both strobes give low byte", b, 8'h7E);
      write_res(10'h0F0);
      read_byte(1'b1, 1'b0, b); check("R9 combined read left pair unlocked", b, 8'hF0);

      // R8: reset in the middle of a lock clears it
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      read_byte(1'b0, 1'b1, b); check("R8 stored zero after reset", b, 8'h00);
      write_res(10'h3C5);
      read_byte(1'b1, 1'b0, b); check("R8 unlocked after reset", b, 8'hC5);
      read_byte(1'b0, 1'b1, b); check("R1 high after reset", b, 8'h03);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule